// File: doc/BRIEF.md
# Two-Channel Break Condition Sequencer

This unit sits beside two external comparators in a debug subsystem. Each comparator pulses a match input when its address or data condition is met. From these pulses the unit decides when to request a debug break. The two channels can act independently, where a match on either one requests a break. They can also be chained, so that a match on channel A must come first before channel B can request the break.

Channel B can also wait for a number of occurrences before it breaks. A 12-bit down-counter is loaded by software. Each accepted channel B match lowers the counter by one, and the break is raised on the match that finds the counter already at 1. A two-entry register port gives access to the mode bits and to the counter. The break request leaves the unit as a registered pulse. Per-channel match flags report what was seen in the previous cycle.

Top module: `brk_seq_unit`

## Requirements
- R1: After reset, the control register (`regAddr`=0) reads 0x0000, the count register (`regAddr`=1) reads 0x0000, and `breakReq`, `flagA` and `flagB` are 0.
- R2: Control register, `regAddr`=0: bit 0 is the count enable and bit 1 is the chained-mode select. All other bits read 0 and ignore writes. Count register, `regAddr`=1: bits 11:0 hold the counter. Bits 15:12 read 0 and ignore writes. Reads are combinational.
- R3: In independent mode (bit 1 = 0), a `matchA` pulse in cycle N raises `breakReq` and `flagA` in cycle N+1.
- R4: In independent mode with counting disabled, a `matchB` pulse in cycle N raises `breakReq` in cycle N+1. The counter is left unchanged.
- R5: With counting enabled, an accepted channel B match seen while the counter is above 1 lowers the counter by exactly one and raises no break.
- R6: With counting enabled, an accepted channel B match seen while the counter holds 1 raises `breakReq`. The counter stays at 1 until it is rewritten.
- R7: With counting enabled and the counter at 0, a channel B match raises no break and leaves the counter at 0.
- R8: In chained mode, `matchA` alone never raises a break. A `matchB` that arrives before any channel A match is ignored: no break, no count change, and `flagB` stays 0.
- R9: In chained mode, once channel A has matched in an earlier cycle, a channel B match that meets the count condition raises the break and disarms the chain. A following channel B match with no new channel A match raises no break.
- R10: In chained mode with the chain not armed, a cycle with both matches arms the chain and ignores channel B.
- R11: In a cycle with `regWrEn` high, a channel B match is ignored: no break, no decrement, and `flagB` stays 0. The written value takes effect.
- R12: A single-cycle match produces a `breakReq` pulse exactly one cycle long.
- R13: `flagB` is high in cycle N+1 exactly when a channel B match in cycle N was accepted, that is, not masked by chained mode or by a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| matchA | input | 1 | Channel A comparator match pulse |
| matchB | input | 1 | Channel B comparator match pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 count |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| breakReq | output | 1 | Break request pulse |
| flagA | output | 1 | Channel A matched in the previous cycle |
| flagB | output | 1 | Channel B match accepted in the previous cycle |

## Verification
The bench walks the counter down to 1 and then fires again. A design that counts down to zero would break one occurrence late, or wrap. It also programs a count of zero, where an off-by-one test would break at once. In chained mode it sends channel B first, then both matches in the same cycle, then A followed by B twice. A design that arms and fires in one cycle, or fails to disarm after the break, would break when it should not. A channel B match that lands on a register write must leave no break and no decrement. A design without write priority would decrement the value that was just written.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrCount;
    logic decCount;
  } brkStrobe_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  brkStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              seqSel,
  output logic              cntEn,
  output logic [CNT_W-1:0]  cntVal,
  output logic              cntIsOne,
  output logic              cntAboveOne
);
  localparam int EN_BIT  = 0;
  localparam int SEQ_BIT = 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntEn  <= 1'b0;
      seqSel <= 1'b0;
      cntVal <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        cntEn  <= wrData[EN_BIT];
        seqSel <= wrData[SEQ_BIT];
      end
      if (strobe.wrCount)
        cntVal <= wrData[CNT_W-1:0];
      else if (strobe.decCount)
        cntVal <= cntVal - ONE;
    end
  end

  assign cntIsOne    = (cntVal == ONE);
  assign cntAboveOne = (cntVal > ONE);

  always_comb begin
    rdData = '0;
    if (rdAddr) begin
      rdData[CNT_W-1:0] = cntVal;
    end else begin
      rdData[EN_BIT]  = cntEn;
      rdData[SEQ_BIT] = seqSel;
    end
  end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       regWrEn,
  input  logic       regAddr,
  input  logic       seqSel,
  input  logic       cntEn,
  input  logic       cntIsOne,
  input  logic       cntAboveOne,
  output brkStrobe_t strobe,
  output logic       breakReq,
  output logic       flagA,
  output logic       flagB
);
  logic armed, armedNext;
  logic bSeen, bFire, aFire, brkNow;

  always_comb begin
    // channel B accepted: no write this cycle, and chain armed if chained
    bSeen  = matchB && !regWrEn && (!seqSel || armed);
    bFire  = bSeen && (!cntEn || cntIsOne);
    aFire  = matchA && !seqSel;
    brkNow = aFire || bFire;

    strobe.wrCtrl   = regWrEn && !regAddr;
    strobe.wrCount  = regWrEn && regAddr;
    strobe.decCount = bSeen && cntEn && cntAboveOne;

    if (!seqSel || bFire) armedNext = 1'b0;
    else                  armedNext = armed || matchA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      breakReq <= 1'b0;
      flagA    <= 1'b0;
      flagB    <= 1'b0;
    end else begin
      armed    <= armedNext;
      breakReq <= brkNow;
      flagA    <= matchA;
      flagB    <= bSeen;
    end
  end
endmodule

// File: rtl/brk_seq_unit.sv
module brk_seq_unit
  import brk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              matchA,
  input  logic              matchB,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              breakReq,
  output logic              flagA,
  output logic              flagB
);
  brkStrobe_t       strobe;
  logic             seqSel, cntEn, cntIsOne, cntAboveOne;
  logic [CNT_W-1:0] cntVal;

  brk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .matchA(matchA), .matchB(matchB),
    .regWrEn(regWrEn), .regAddr(regAddr), .seqSel(seqSel), .cntEn(cntEn),
    .cntIsOne(cntIsOne), .cntAboveOne(cntAboveOne), .strobe(strobe),
    .breakReq(breakReq), .flagA(flagA), .flagB(flagB)
  );

  brk_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(regWrData),
    .rdAddr(regAddr), .rdData(regRdData), .seqSel(seqSel), .cntEn(cntEn),
    .cntVal(cntVal), .cntIsOne(cntIsOne), .cntAboveOne(cntAboveOne)
  );
endmodule

// File: rtl/brk_seq_unit_chk.sv
module brk_seq_unit_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              matchA,
  input logic              matchB,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              breakReq,
  input logic              flagB,
  input logic              seqSel,
  input logic              cntEn,
  input logic [CNT_W-1:0]  cntVal
);
  // R3
  break_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    breakReq |-> $past(matchA || matchB));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regAddr |-> (regRdData[DATA_W-1:CNT_W] == '0));

  // R11
  wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(regWrEn) |-> !flagB);

  // R6
  hold_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cntVal) == CNT_W'(1) && !$past(regWrEn)) |-> cntVal == CNT_W'(1));

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cntEn && matchB && !regWrEn && !seqSel && cntVal > CNT_W'(1))
      |-> cntVal == $past(cntVal) - CNT_W'(1));

  // R8
  seq_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seqSel) && !$past(matchB)) |-> !breakReq);
endmodule

bind brk_seq_unit brk_seq_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .matchA(matchA), .matchB(matchB),
  .regWrEn(regWrEn), .regAddr(regAddr), .regRdData(regRdData),
  .breakReq(breakReq), .flagB(flagB), .seqSel(seqSel), .cntEn(cntEn),
  .cntVal(cntVal)
);

// File: tb/brk_seq_unit_tb.sv
module brk_seq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        matchA = 1'b0, matchB = 1'b0, regWrEn = 1'b0, regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        breakReq, flagA, flagB;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  typedef struct {
    logic  brk;
    logic  fa;
    logic  fb;
    string tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  brk_seq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .matchA(matchA), .matchB(matchB),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .breakReq(breakReq), .flagA(flagA), .flagB(flagB)
  );

  // monitor: compares outputs after each edge against the oldest expectation
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      nChecks++;
      if ({breakReq, flagA, flagB} !== {e.brk, e.fa, e.fb}) begin
        nFails++;
        $display("FAIL %s: brk/fa/fb actual %b%b%b expected %b%b%b",
                 e.tag, breakReq, flagA, flagB, e.brk, e.fa, e.fb);
      end
    end
  end

  task automatic step(input logic a, input logic b, input logic we,
                      input logic ad, input logic [15:0] d,
                      input logic eb, input logic efa, input logic efb,
                      input string tag);
    item_t e;
    @(negedge clk);
    matchA = a; matchB = b; regWrEn = we; regAddr = ad; regWrData = d;
    e.brk = eb; e.fa = efa; e.fb = efb; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wr(input logic ad, input logic [15:0] d, input string tag);
    step(1'b0, 1'b0, 1'b1, ad, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rdChk(input logic ad, input logic [15:0] exp, input string tag);
    @(negedge clk);
    matchA = 0; matchB = 0; regWrEn = 0; regAddr = ad;
    #1;
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s: read actual %h expected %h", tag, regRdData, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rdChk(0, 16'h0000, "R1 ctrl");
    rdChk(1, 16'h0000, "R1 count");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1 outputs");
    // R2 register map
    wr(0, 16'hFFFF, "R2 wr");
    rdChk(0, 16'h0003, "R2 ctrl reserved");
    wr(0, 16'h0000, "R2 wr");
    wr(1, 16'hFABC, "R2 wr");
    rdChk(1, 16'h0ABC, "R2 count upper");
    // R3/R12 independent channel A
    step(1, 0, 0, 0, 0, 1, 1, 0, "R3 a break");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R12 pulse");
    // R4/R13 channel B no count
    step(0, 1, 0, 0, 0, 1, 0, 1, "R4 b break");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R12 pulse b");
    rdChk(1, 16'h0ABC, "R4 count unchanged");
    // R5/R6 counting
    wr(0, 16'h0001, "R5 wr");
    wr(1, 16'h0003, "R5 wr");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R5 dec 3");
    rdChk(1, 16'h0002, "R5 count 2");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R5 dec 2");
    rdChk(1, 16'h0001, "R5 count 1");
    step(0, 1, 0, 0, 0, 1, 0, 1, "R6 break at 1");
    rdChk(1, 16'h0001, "R6 holds 1");
    step(0, 1, 0, 0, 0, 1, 0, 1, "R6 break again");
    step(1, 0, 0, 0, 0, 1, 1, 0, "R3 a with counting");
    // R7 count zero
    wr(1, 16'h0000, "R7 wr");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R7 no break");
    rdChk(1, 16'h0000, "R7 stays 0");
    // R11 write priority
    step(0, 1, 1, 1, 16'h0005, 0, 0, 0, "R11 wr count with b");
    rdChk(1, 16'h0005, "R11 written value");
    wr(1, 16'h0001, "R11 wr");
    step(0, 1, 1, 0, 16'h0001, 0, 0, 0, "R11 wr ctrl with b");
    rdChk(1, 16'h0001, "R11 no decrement");
    // R8/R9/R10 chained mode
    wr(0, 16'h0002, "R8 wr");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R8 b before a");
    step(1, 0, 0, 0, 0, 0, 1, 0, "R8 a alone");
    step(0, 1, 0, 0, 0, 1, 0, 1, "R9 armed b");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R9 disarmed");
    step(1, 1, 0, 0, 0, 0, 1, 0, "R10 same cycle");
    step(0, 1, 0, 0, 0, 1, 0, 1, "R10 then b");
    // chained with counting
    wr(0, 16'h0003, "R9 wr");
    wr(1, 16'h0002, "R9 wr");
    step(1, 0, 0, 0, 0, 0, 1, 0, "R9 arm");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R5 chained dec");
    rdChk(1, 16'h0001, "R5 chained count 1");
    step(0, 1, 0, 0, 0, 1, 0, 1, "R9 chained break");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R12 idle");
    repeat (3) @(posedge clk);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule